// File: doc/BRIEF.md
# Audio Transmit FIFO with Refill Interrupt

This block buffers outgoing audio words between a register-side writer and a serial-port shifter that pulls one word at a time. It holds up to 32 words of 32 bits, shows its current fill count, and raises a level-sensitive refill request whenever the count has dropped to a programmable low-water mark or below. Software can then top the buffer up in one burst.

If the shifter asks for a word while the buffer is empty, it receives zero and a sticky underrun flag is set. That flag stays set until software writes the clear strobe. A flush strobe empties the buffer. Its busy indication reads high for exactly one cycle and then drops by itself. Each of the two status flags has its own enable. The interrupt line is the OR of the enabled flags and is formed without further registering.

Top module: `atx_fifo_top`

## Requirements
- R1: After reset the level is 0, the underrun flag is 0, the flush busy indication is 0, rd_valid is 0 and rd_data is 0.
- R2: A write (wr_en high) taken while the level is below 32 stores wr_data and raises the level by one on the next cycle. A write and a read that are both taken in the same cycle leave the level unchanged.
- R3: A write while the level is 32 is dropped, even if a read is requested in the same cycle. The stored contents are unchanged, and with no read the level stays 32. The level is a 6-bit count that reaches 32.
- R4: A read request taken while the level is nonzero presents the oldest stored word on rd_data with rd_valid high in the cycle after the request. Words leave in write order.
- R5: A read request while the level is 0 gives rd_valid 0 and rd_data 0 in the next cycle, and it sets the underrun flag, which is status bit 1.
- R6: The underrun flag stays set until an under_clr pulse clears it. If an empty read and under_clr arrive in the same cycle, the flag ends up set.
- R7: Status bit 0 is 1 exactly when the level is less than or equal to the 5-bit thresh input.
- R8: irq equals (status[0] AND low_ie) OR (status[1] AND under_ie), formed combinationally from registered state.
- R9: A flush_set pulse makes flush_busy 1 on the next cycle. One cycle later flush_busy returns to 0 and the level is 0. Writes and reads during the busy cycle are ignored and return no data. The words that follow the flush are read out first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the register side |
| wr_data | input | 32 | Word to store |
| rd_req | input | 1 | Word request from the shifter |
| rd_data | output | 32 | Word answering the previous request, zero if none |
| rd_valid | output | 1 | rd_data holds a stored word |
| thresh | input | 5 | Low-water mark for status bit 0 |
| low_ie | input | 1 | Enable of the low-water interrupt |
| under_ie | input | 1 | Enable of the underrun interrupt |
| under_clr | input | 1 | Pulse that clears the underrun flag |
| flush_set | input | 1 | Pulse that requests a flush |
| flush_busy | output | 1 | Flush pending; drops by itself |
| level | output | 6 | Number of stored words, 0 to 32 |
| status | output | 2 | Bit 0 low-water, bit 1 underrun |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that wr_en, rd_req, flush_set and under_clr are sampled as plain single-cycle strobes that are meaningful on every edge. They also assume that thresh and the enables change only between edges. The stimulus drives every input on the falling edge and returns each strobe to zero after one rising edge, so no strobe is ever half-sampled. The bench never reads or writes during a flush-busy cycle except where it deliberately checks that such accesses are ignored. In that case its queue model drops them as well.

// File: rtl/atx_fifo_pkg.sv
package atx_fifo_pkg;
    // status word bit positions (software decodes these)
    localparam int ST_LOW_BIT   = 0;
    localparam int ST_UNDER_BIT = 1;
    localparam int ST_W         = 2;
endpackage

// File: rtl/atx_fifo_mem.sv
module atx_fifo_mem #(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/atx_fifo_ctrl.sv
module atx_fifo_ctrl #(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_req,
    input  logic          flush_set,
    input  logic          under_clr,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW-1:0] mem_raddr,
    output logic          pop,
    output logic [LW-1:0] level,
    output logic          flush_busy,
    output logic          under_flag
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] lvl;
        logic          flush;
        logic          under;
    } ctrl_t;

    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    ctrl_t st_d, st_q;
    logic  push;

    always_comb begin
        st_d = st_q;
        push = 1'b0;
        pop  = 1'b0;
        if (st_q.flush) begin
            st_d.wp    = '0;
            st_d.rp    = '0;
            st_d.lvl   = '0;
            st_d.flush = flush_set;
        end else begin
            push = wr_en && (st_q.lvl != FULL_LVL);
            pop  = rd_req && (st_q.lvl != '0);
            if (push) begin
                st_d.wp = (st_q.wp == LAST_PTR) ? '0 : st_q.wp + 1'b1;
            end
            if (pop) begin
                st_d.rp = (st_q.rp == LAST_PTR) ? '0 : st_q.rp + 1'b1;
            end
            if (push && !pop) begin
                st_d.lvl = st_q.lvl + 1'b1;
            end else if (pop && !push) begin
                st_d.lvl = st_q.lvl - 1'b1;
            end
            if (flush_set) begin
                st_d.flush = 1'b1;
            end
        end
        if (under_clr) begin
            st_d.under = 1'b0;
        end
        // an empty read wins over a simultaneous clear
        if (!st_q.flush && rd_req && (st_q.lvl == '0)) begin
            st_d.under = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we     = push;
    assign mem_waddr  = st_q.wp;
    assign mem_raddr  = st_q.rp;
    assign level      = st_q.lvl;
    assign flush_busy = st_q.flush;
    assign under_flag = st_q.under;
endmodule

// File: rtl/atx_fifo_irq.sv
module atx_fifo_irq
    import atx_fifo_pkg::*;
#(
    parameter int LW = 6,
    parameter int TW = 5
) (
    input  logic [LW-1:0]   level,
    input  logic [TW-1:0]   thresh,
    input  logic            under_flag,
    input  logic [ST_W-1:0] enables,
    output logic [ST_W-1:0] status,
    output logic            irq
);
    logic [ST_W-1:0] masked;

    always_comb begin
        status               = '0;
        status[ST_LOW_BIT]   = (level <= LW'(thresh));
        status[ST_UNDER_BIT] = under_flag;
    end

    for (genvar b = 0; b < ST_W; b++) begin : g_mask
        assign masked[b] = status[b] & enables[b];
    end

    assign irq = |masked;
endmodule

// File: rtl/atx_fifo_top.sv
module atx_fifo_top
    import atx_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_req,
    output logic [DW-1:0]   rd_data,
    output logic            rd_valid,
    input  logic [AW-1:0]   thresh,
    input  logic            low_ie,
    input  logic            under_ie,
    input  logic            under_clr,
    input  logic            flush_set,
    output logic            flush_busy,
    output logic [LW-1:0]   level,
    output logic [ST_W-1:0] status,
    output logic            irq
);
    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } rdout_t;

    logic          mem_we, pop, under_flag;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0] mem_rdata;
    logic [ST_W-1:0] enables;
    rdout_t        out_d, out_q;

    atx_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_req(rd_req),
        .flush_set(flush_set), .under_clr(under_clr),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_raddr(mem_raddr),
        .pop(pop), .level(level), .flush_busy(flush_busy),
        .under_flag(under_flag)
    );

    atx_fifo_mem #(.DEPTH(DEPTH), .DW(DW)) mem_i (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    always_comb begin
        enables               = '0;
        enables[ST_LOW_BIT]   = low_ie;
        enables[ST_UNDER_BIT] = under_ie;
    end

    atx_fifo_irq #(.LW(LW), .TW(AW)) irq_i (
        .level(level), .thresh(thresh), .under_flag(under_flag),
        .enables(enables), .status(status), .irq(irq)
    );

    always_comb begin
        out_d.valid = pop;
        out_d.data  = pop ? mem_rdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_data  = out_q.data;
    assign rd_valid = out_q.valid;
endmodule

// File: rtl/atx_fifo_chk.sv
module atx_fifo_chk #(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_req,
    input logic          rd_valid,
    input logic [31:0]   rd_data,
    input logic [AW-1:0] thresh,
    input logic          low_ie,
    input logic          under_ie,
    input logic          under_clr,
    input logic          flush_set,
    input logic          flush_busy,
    input logic [LW-1:0] level,
    input logic [1:0]    status,
    input logic          irq
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    p_level_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level == FULL_LVL && wr_en && !rd_req && !flush_busy) |=> level == FULL_LVL);

    p_write_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (level < FULL_LVL && wr_en && !rd_req && !flush_busy) |=> level == $past(level) + 1'b1);

    p_pop_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && level != '0 && !flush_busy) |=> rd_valid);

    p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && level == '0 && !flush_busy) |=> (status[1] && !rd_valid && rd_data == '0));

    p_under_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !under_clr) |=> status[1]);

    p_low_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] == (level <= LW'(thresh)));

    p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((status[0] && low_ie) || (status[1] && under_ie)));

    p_flush_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |=> (level == '0 && !rd_valid));

    p_flush_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_set && !flush_busy) |=> flush_busy);
endmodule

bind atx_fifo_top atx_fifo_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .thresh(thresh),
    .low_ie(low_ie), .under_ie(under_ie), .under_clr(under_clr),
    .flush_set(flush_set), .flush_busy(flush_busy), .level(level),
    .status(status), .irq(irq)
);

// File: tb/atx_fifo_top_tb_top.sv
module atx_fifo_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_req = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [4:0]  thresh = 5'd1;
    logic        low_ie = 1'b0, under_ie = 1'b0, under_clr = 1'b0, flush_set = 1'b0;
    logic        flush_busy, irq;
    logic [5:0]  level;
    logic [1:0]  status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] model_q[$];
    bit          m_under = 1'b0;
    bit          m_flush = 1'b0;

    always #2 clk = ~clk;

    atx_fifo_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
        .thresh(thresh), .low_ie(low_ie), .under_ie(under_ie),
        .under_clr(under_clr), .flush_set(flush_set),
        .flush_busy(flush_busy), .level(level), .status(status), .irq(irq)
    );

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [5:0] lvl;
    } vec_t;

    localparam vec_t VEC [13] = '{
        '{1'b1, 1'b0, 6'd1}, '{1'b1, 1'b0, 6'd2}, '{1'b1, 1'b0, 6'd3},
        '{1'b0, 1'b1, 6'd2}, '{1'b1, 1'b1, 6'd2}, '{1'b1, 1'b0, 6'd3},
        '{1'b0, 1'b1, 6'd2}, '{1'b0, 1'b1, 6'd1}, '{1'b1, 1'b1, 6'd1},
        '{1'b0, 1'b1, 6'd0}, '{1'b0, 1'b0, 6'd0}, '{1'b1, 1'b0, 6'd1},
        '{1'b0, 1'b1, 6'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock with the queue model; checks read result and level
    task automatic step(input bit w, input logic [31:0] d, input bit r, input string req);
        bit          exp_v = 1'b0;
        logic [31:0] exp_d = '0;
        bit          next_flush;
        wr_en = w; wr_data = d; rd_req = r;
        if (m_flush) begin
            model_q.delete();
            next_flush = flush_set;
        end else begin
            bit was_empty = (model_q.size() == 0);
            bit was_full  = (model_q.size() >= 32);
            if (r && !was_empty) begin
                exp_v = 1'b1;
                exp_d = model_q.pop_front();
            end
            if (w && !was_full) model_q.push_back(d);
            next_flush = flush_set;
            if (under_clr) m_under = 1'b0;
            if (r && was_empty) m_under = 1'b1;
        end
        if (m_flush && under_clr) m_under = 1'b0;
        m_flush = next_flush;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_req = 1'b0; flush_set = 1'b0; under_clr = 1'b0;
        if (r) begin
            chk({req, " rd_valid"}, 32'(rd_valid), 32'(exp_v));
            chk({req, " rd_data"}, rd_data, exp_d);
        end
        chk({req, " level"}, 32'(level), 32'(model_q.size()));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1..all actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 level", 32'(level), 32'd0);
        chk("R1 underrun", 32'(status[1]), 32'd0);
        chk("R1 flush_busy", 32'(flush_busy), 32'd0);
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        chk("R1 rd_data", rd_data, 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);

        // vector table: R2 R4 R7 with thresh 1
        for (int i = 0; i < 13; i++) begin
            step(VEC[i].wr, 32'hC0DE_0000 + 32'(i), VEC[i].rd, "R2/R4 vec");
            chk("R2 table level", 32'(level), 32'(VEC[i].lvl));
            chk("R7 low mark", 32'(status[0]), 32'(VEC[i].lvl <= 6'd1));
        end

        // fill to the top: R10-style count of 32, R3 overflow
        for (int i = 0; i < 32; i++) step(1'b1, 32'hA500_0000 + 32'(i), 1'b0, "R2 fill");
        chk("R3 full level 32", 32'(level), 32'd32);
        thresh = 5'd31;
        @(negedge clk);
        chk("R7 32 above 31", 32'(status[0]), 32'd0);
        step(1'b1, 32'hDEAD_BEEF, 1'b0, "R3 overflow write");
        chk("R3 level held", 32'(level), 32'd32);
        step(1'b1, 32'hBAD0_BAD0, 1'b1, "R3 write+read when full");
        chk("R3 full rw level", 32'(level), 32'd31);
        chk("R7 31 at 31", 32'(status[0]), 32'd1);
        // drain, order checked by model (R4)
        for (int i = 0; i < 31; i++) step(1'b0, '0, 1'b1, "R4 drain order");

        // R5 empty read, R8 masking
        thresh = 5'd0;
        step(1'b0, '0, 1'b1, "R5 empty read");
        chk("R5 underrun set", 32'(status[1]), 32'd1);
        low_ie = 1'b0; under_ie = 1'b0;
        @(negedge clk);
        chk("R8 all masked", 32'(irq), 32'd0);
        under_ie = 1'b1;
        @(negedge clk);
        chk("R8 underrun irq", 32'(irq), 32'd1);
        under_ie = 1'b0; low_ie = 1'b1;
        @(negedge clk);
        chk("R8 low irq", 32'(irq), 32'd1);

        // R6 sticky and clear
        step(1'b1, 32'h0000_1111, 1'b0, "R6 idle");
        chk("R6 still set", 32'(status[1]), 32'd1);
        chk("R8 low masked by level", 32'(irq), 32'd0);
        under_clr = 1'b1;
        step(1'b0, '0, 1'b1, "R6 clear cycle");
        chk("R6 cleared", 32'(status[1]), 32'd0);
        under_clr = 1'b1;
        step(1'b0, '0, 1'b1, "R6 set beats clear");
        chk("R6 set wins", 32'(status[1]), 32'd1);
        under_clr = 1'b1;
        step(1'b0, '0, 1'b0, "R6 clear");
        chk("R6 clear again", 32'(status[1]), 32'd0);

        // R9 flush
        for (int i = 0; i < 5; i++) step(1'b1, 32'h5EED_0000 + 32'(i), 1'b0, "R9 prefill");
        flush_set = 1'b1;
        step(1'b0, '0, 1'b0, "R9 request");
        chk("R9 busy", 32'(flush_busy), 32'd1);
        chk("R9 level before", 32'(level), 32'd5);
        step(1'b1, 32'hFFFF_0000, 1'b1, "R9 busy cycle ignored");
        chk("R9 busy self-clear", 32'(flush_busy), 32'd0);
        chk("R9 emptied", 32'(level), 32'd0);
        chk("R9 no underrun", 32'(status[1]), 32'd0);
        step(1'b1, 32'h7777_0001, 1'b0, "R9 refill");
        step(1'b1, 32'h7777_0002, 1'b0, "R9 refill");
        step(1'b0, '0, 1'b1, "R9 new order");
        chk("R9 first after flush", rd_data, 32'h7777_0001);
        step(1'b0, '0, 1'b1, "R9 new order");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule